// File: doc/BRIEF.md
# Dual-Segment DAC Code Splitter

This block takes one signed PCM sample per strobe and turns it into two unsigned 16-bit codes. Each code drives one unipolar DAC segment. The output currents of the two segments are summed outside the chip, which gives a single 17-bit mono converter.

The sample is first rebased from two's complement to offset binary. It is then cut or extended to a 17-bit working word. The top bit of that word is never sent to a segment. It is kept in a register and chooses which segment carries the magnitude:

- In the lower half of the range, segment A rests at zero and segment B follows the word.
- In the upper half, segment B rests at full scale and segment A follows the word plus one.

As a result, the move through bipolar zero is a one-LSB step on a single segment. No segment ever sees every bit flip at once.

The sample path accepts either a wide sample, which is truncated, or a 16-bit sample, which is padded with a chosen bit. Both codes and the steering bit are loaded together on one sample strobe. Between strobes they hold.

Top module: `dual_seg_splitter`

## Requirements
- R1: The sample is read as two's complement and rebased to offset binary by inverting only its top bit. The most negative input maps to working word 0, and input zero maps to 0x10000.
- R2: In wide mode (shortWord=0), the working word is the upper 17 bits of the 24-bit sampleIn. Bits 6..0 have no effect on either code.
- R3: In short mode (shortWord=1), the 16-bit sample sits in sampleIn[15:0], and sampleIn[23:16] has no effect. The working word is that sample followed by padBit as its new least significant bit.
- R4: When the top bit of the working word is 0, segACode is 0x0000 and segBCode equals the lower 16 bits of the word.
- R5: When the top bit of the working word is 1, segBCode is 0xFFFF and segACode equals the lower 16 bits plus one. segACode is therefore never zero in this half.
- R6: When the lower 16 bits are 0xFFFF and the top bit is 1, segACode saturates at 0xFFFF instead of wrapping to zero.
- R7: Both codes change only in the clock cycle after a cycle with sampleValid high. Without a strobe, input changes have no effect on either code.
- R8: After reset, the outputs hold the bipolar-zero codes: segACode = 0x0001 and segBCode = 0xFFFF.
- R9: A nonzero segACode is only ever seen together with segBCode = 0xFFFF. Stepping the input from one code below bipolar zero to bipolar zero changes only segACode, and only from 0x0000 to 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | One-cycle strobe that loads a new sample |
| shortWord | input | 1 | 1: 16-bit sample in the low bits; 0: wide sample |
| padBit | input | 1 | Bit appended as the LSB in short mode |
| sampleIn | input | IN_W (24) | Two's-complement sample |
| segACode | output | 16 | Code for the segment used in the upper half |
| segBCode | output | 16 | Code for the segment used in the lower half |

## Verification
The assertions assume that sampleValid is a synchronous level, sampled only at rising edges, and that reset is low long enough for the registers to settle.

Every other input is free: any sample, mode or pad bit must leave the segment pair in a legal state. The stimulus changes inputs only on falling edges and raises sampleValid for single cycles. Between strobes it also changes sampleIn with the strobe low, so that the hold property is exercised against live input changes rather than a quiet bus.

// File: rtl/seg_splitter_pkg.sv
package seg_splitter_pkg;
  // Strobes handed from control to datapath
  typedef struct packed {
    logic loadWord;
    logic useShort;
    logic padValue;
  } split_ctrl_t;
endpackage

// File: rtl/seg_splitter_ctrl.sv
module seg_splitter_ctrl
  import seg_splitter_pkg::*;
(
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        shortWord,
  input  logic        padBit,
  output split_ctrl_t strobes
);
  // A strobe seen while reset is held is dropped
  always_comb begin
    strobes.loadWord = sampleValid & rstN;
    strobes.useShort = shortWord;
    strobes.padValue = padBit;
  end
endmodule

// File: rtl/seg_splitter_datapath.sv
module seg_splitter_datapath
  import seg_splitter_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  split_ctrl_t      strobes,
  input  logic [IN_W-1:0]  sampleIn,
  output logic [SEG_W-1:0] segACode,
  output logic [SEG_W-1:0] segBCode,
  output logic             steerSign
);
  localparam int WORK_W = SEG_W + 1;
  localparam logic [SEG_W-1:0] SEG_ZERO = '0;
  localparam logic [SEG_W-1:0] SEG_FULL = '1;
  localparam logic [SEG_W-1:0] SEG_ONE  = SEG_W'(1);

  logic [WORK_W-1:0] wideWord;
  logic [WORK_W-1:0] shortWordVal;
  logic [WORK_W-1:0] workWord;
  logic [SEG_W-1:0]  lowPart;
  logic [SEG_W-1:0]  incPart;
  logic              topBit;
  logic [SEG_W-1:0]  nextA;
  logic [SEG_W-1:0]  nextB;

  // Wide path: keep the upper bits, drop the rest (or zero-fill a narrow bus)
  generate
    if (IN_W >= WORK_W) begin : gTruncate
      assign wideWord = {~sampleIn[IN_W-1], sampleIn[IN_W-2 -: SEG_W]};
    end else begin : gExtend
      assign wideWord = {~sampleIn[IN_W-1], sampleIn[IN_W-2:0], {(WORK_W-IN_W){1'b0}}};
    end
  endgenerate

  // Short path: 16-bit sample in the low bits, pad bit becomes the new LSB
  assign shortWordVal = {~sampleIn[SEG_W-1], sampleIn[SEG_W-2:0], strobes.padValue};

  always_comb begin
    workWord = strobes.useShort ? shortWordVal : wideWord;
    topBit   = workWord[WORK_W-1];
    lowPart  = workWord[SEG_W-1:0];
    // Saturating increment for the upper-half segment
    incPart  = (lowPart == SEG_FULL) ? SEG_FULL : lowPart + SEG_ONE;
    if (topBit) begin
      nextA = incPart;
      nextB = SEG_FULL;
    end else begin
      nextA = SEG_ZERO;
      nextB = lowPart;
    end
  end

  // Codes and steering bit load together; reset lands on bipolar zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segACode  <= SEG_ONE;
      segBCode  <= SEG_FULL;
      steerSign <= 1'b1;
    end else if (strobes.loadWord) begin
      segACode  <= nextA;
      segBCode  <= nextB;
      steerSign <= topBit;
    end
  end
endmodule

// File: rtl/dual_seg_splitter.sv
module dual_seg_splitter
  import seg_splitter_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             shortWord,
  input  logic             padBit,
  input  logic [IN_W-1:0]  sampleIn,
  output logic [SEG_W-1:0] segACode,
  output logic [SEG_W-1:0] segBCode
);
  split_ctrl_t strobes;
  logic        steerSign;

  seg_splitter_ctrl ctrl (
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .shortWord   (shortWord),
    .padBit      (padBit),
    .strobes     (strobes)
  );

  seg_splitter_datapath #(.IN_W(IN_W), .SEG_W(SEG_W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleIn  (sampleIn),
    .segACode  (segACode),
    .segBCode  (segBCode),
    .steerSign (steerSign)
  );
endmodule

// File: rtl/dual_seg_splitter_checker.sv
module dual_seg_splitter_checker #(
  parameter int SEG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic [SEG_W-1:0] segACode,
  input logic [SEG_W-1:0] segBCode,
  input logic             steerSign
);
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(segACode) && $stable(segBCode) && $stable(steerSign))); // R7
  AST_LOW_HALF_A_REST: assert property (@(posedge clk) disable iff (!rstN)
    !steerSign |-> (segACode == '0)); // R4
  AST_HIGH_HALF_B_FULL: assert property (@(posedge clk) disable iff (!rstN)
    steerSign |-> (segBCode == '1)); // R5
  AST_HIGH_HALF_A_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    steerSign |-> (segACode != '0)); // R5
  AST_A_NEEDS_B_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (segACode != '0) |-> (segBCode == '1)); // R9
endmodule

bind dual_seg_splitter dual_seg_splitter_checker #(.SEG_W(SEG_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .segACode    (segACode),
  .segBCode    (segBCode),
  .steerSign   (steerSign)
);

// File: tb/dual_seg_splitter_test.sv
module dual_seg_splitter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic        shortWord = 1'b0;
  logic        padBit = 1'b0;
  logic [23:0] sampleIn = '0;
  logic [15:0] segACode;
  logic [15:0] segBCode;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastExp;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_seg_splitter uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .shortWord(shortWord),
    .padBit(padBit), .sampleIn(sampleIn), .segACode(segACode), .segBCode(segBCode)
  );

  // Expected codes from the requirements, using plain arithmetic
  function automatic logic [31:0] model(logic [23:0] s, bit sh, bit pd);
    int unsigned w, a, b;
    if (sh) w = ({16'd0, s[15:0] ^ 16'h8000} * 2) + {31'd0, pd};  // R3, R1
    else    w = {8'd0, s ^ 24'h800000} / 128;                     // R2, R1
    if (w >= 65536) begin                                         // R5
      a = w - 65536 + 1;
      if (a > 65535) a = 65535;                                   // R6
      b = 65535;
    end else begin                                                // R4
      a = 0;
      b = w;
    end
    return {a[15:0], b[15:0]};
  endfunction

  task automatic compareNow(logic [31:0] exp, string tag);
    compared++;
    if ({segACode, segBCode} !== exp) begin
      mismatched++;
      $display("FAIL %s: A=%h B=%h expected A=%h B=%h", tag,
               segACode, segBCode, exp[31:16], exp[15:0]);
    end
  endtask

  task automatic sendSample(logic [23:0] s, bit sh, bit pd, string tag);
    @(negedge clk);
    sampleIn = s; shortWord = sh; padBit = pd; sampleValid = 1'b1;
    lastExp = model(s, sh, pd);
    expQ.push_back(lastExp);
    tagQ.push_back(tag);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Monitor: one result per accepted strobe, one cycle after it
  initial begin
    forever begin
      @(posedge clk);
      if (sampleValid && rstN) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R7: update without expected item, A=%h B=%h expected none",
                   segACode, segBCode);
        end else begin
          compareNow(expQ.pop_front(), tagQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    compared++; mismatched++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finishRun();
  end

  initial begin
    int unsigned seed = 32'h1357_9bdf;
    repeat (3) @(negedge clk);
    compareNow(32'h0001_ffff, "R8 reset codes");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    compareNow(32'h0001_ffff, "R8 after release");

    sendSample(24'h800000, 0, 0, "R1 negative full scale");
    sendSample(24'h800080, 0, 0, "R4 one step above -FS");
    sendSample(24'h123400, 0, 0, "R5 mid upper half");
    sendSample(24'hffff80, 0, 0, "R9 just below zero");
    sendSample(24'h000000, 0, 0, "R9 bipolar zero");
    sendSample(24'h000080, 0, 0, "R5 one above zero");
    sendSample(24'h00007f, 0, 0, "R2 low bits ignored");
    sendSample(24'h7fff00, 0, 0, "R6 one below +FS");
    sendSample(24'h7fffff, 0, 0, "R6 positive full scale");
    sendSample(24'hc00040, 0, 1, "R4 lower half pad ignored");
    sendSample(24'h008000, 1, 0, "R3 short -FS");
    sendSample(24'hab0000, 1, 1, "R3 short zero pad one");
    sendSample(24'h00ffff, 1, 0, "R3 short -1 pad zero");
    sendSample(24'h55ffff, 1, 1, "R3 short -1 pad one");
    sendSample(24'h007fff, 1, 1, "R6 short +FS pad one");
    for (int i = 0; i < 20; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      sendSample(seed[31:8], seed[3], seed[5], "R1 sweep");
    end
    @(negedge clk);

    // R7: live input changes without a strobe
    for (int i = 0; i < 4; i++) begin
      sampleIn = 24'h800000 ^ (24'h111111 * i);
      shortWord = i[0];
      padBit = i[1];
      @(negedge clk);
      compareNow(lastExp, "R7 hold without strobe");
    end
    if (expQ.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R7: %0d results missing, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule